// File: doc/BRIEF.md
# DDR SDRAM Bank Precharge Timing Tracker

This block follows one bank of a double data rate SDRAM and tells a command scheduler, in every clock cycle, whether a Precharge or an Activate to that bank would be legal in the current cycle. It watches four command strobes: Activate, Read, Read with automatic precharge, and Precharge. It applies the minimum row-open time. It places the internal precharge that an automatic-precharge read triggers. It converts the row precharge time from picoseconds into whole clock cycles. It also reports the cycles in which read data occupies the data bus, including the case where a Precharge ends a burst early.

All configuration inputs are static while the bank is busy. These are the CAS latency, the burst length (2, 4, 8 or 16 beats, with two beats per clock), the minimum row-open time in cycles, and the precharge time and clock period in picoseconds. No data stream passes through the block, so it has no valid/ready handshake. Every pin is a plain control or status signal. The scheduler checks `pre_ok` and `act_ok` before it issues a command. A command that is issued anyway is rejected, and the rejection is reported on `violation`.

Top module: `bank_pre_tracker`

## Requirements
- R1: After reset the bank is idle: `act_ok`=1, `pre_ok`=0, `pre_cut`=0, `auto_pre_start`=0, `dq_busy`=0, `violation`=0.
- R2: After an Activate accepted in cycle A, `pre_ok` is 0 in cycles A+1 to A+tRAS-1 and becomes 1 in cycle A+tRAS, provided no automatic precharge is pending.
- R3: A Precharge issued while `pre_ok`=0, including one to an idle or precharging bank, makes `violation`=1 in the next cycle and leaves the bank state unchanged.
- R4: `pre_cut` is 1 exactly when `pre_ok`=1 and fewer than BL/2 cycles have passed since the latest Read in the open row. A Precharge in such a cycle truncates the burst but is still accepted.
- R5: After a precharge starts in cycle P, `act_ok` is 0 until cycle P+N and is 1 from cycle P+N, where N is the precharge time in cycles.
- R6: N = ceil(tRP_ps / tCK_ps), with a minimum of 1. An exact multiple does not round up.
- R7: For a Read with automatic precharge in cycle R, with the row opened in cycle A, `auto_pre_start` pulses for one cycle in cycle max(R+BL/2, A+tRAS). `pre_ok` stays 0 while the internal precharge is pending, and R5 counts from the pulse.
- R8: A Read (either kind) to a bank that is not open, or while an automatic precharge is pending, makes `violation`=1 in the next cycle and is ignored.
- R9: An Activate while `act_ok`=0 makes `violation`=1 in the next cycle and is ignored.
- R10: Two or more strobes in the same cycle make `violation`=1 in the next cycle, and all of them are ignored. As a result, a Precharge always comes at least one clock after the Read.
- R11: For a Read in cycle R, `dq_busy` is 1 in cycles R+CL to R+CL+BL/2-1.
- R12: A Precharge in cycle P that cuts a burst short makes cycle P+CL-1 the last cycle with `dq_busy`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_act | input | 1 | Activate strobe |
| cmd_rd | input | 1 | Read strobe |
| cmd_rd_ap | input | 1 | Read with automatic precharge strobe |
| cmd_pre | input | 1 | Precharge strobe |
| cfg_cl | input | CL_W (3) | CAS latency in cycles |
| cfg_bl | input | BL_W (5) | Burst length in beats (2, 4, 8, 16) |
| cfg_tras | input | CNT_W (8) | Minimum row-open time in cycles |
| cfg_trp_ps | input | PS_W (16) | Precharge time in picoseconds |
| cfg_tck_ps | input | PS_W (16) | Clock period in picoseconds |
| act_ok | output | 1 | An Activate in this cycle would be accepted |
| pre_ok | output | 1 | A Precharge in this cycle would be accepted |
| pre_cut | output | 1 | A Precharge in this cycle would truncate the current burst |
| auto_pre_start | output | 1 | The internal precharge of an automatic-precharge read starts in this cycle |
| dq_busy | output | 1 | Read data occupies the bus in this cycle |
| violation | output | 1 | The command in the previous cycle was rejected |

## Verification
The permission outputs (`act_ok`, `pre_ok`, `pre_cut`, `auto_pre_start`, `dq_busy`) depend only on registered state. A command accepted at the edge that ends cycle c can therefore first change them in cycle c+1. The row-open, precharge and bus windows are counted from that cycle. `violation` is registered and appears in cycle c+1 for a command issued in cycle c. The bench gives each expectation an absolute cycle number computed from the requirement formulas. It drives strobes just after the falling edge and compares at the falling edge of exactly that cycle. The comparison therefore never depends on process order at the rising edge.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_PRECH = 2'd2
  } bank_st_t;

  // Index of each elapsed-cycle timer in the timer bank
  localparam int TMR_RAS = 0;
  localparam int TMR_TRP = 1;
  localparam int TMR_RD  = 2;
  localparam int TMR_N   = 3;

endpackage

// File: rtl/bank_sat_timer.sv
// Elapsed-cycle counter: loads 1 on restart, then counts up and saturates.
module bank_sat_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CAP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (restart)       cnt <= W'(1);
    else if (cnt != CAP)    cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/bank_trp_ceil.sv
// Converts a precharge time into whole clock cycles, rounding up, minimum 1.
module bank_trp_ceil #(
  parameter int PS_W  = 16,
  parameter int CNT_W = 8
) (
  input  logic [PS_W-1:0]  trp_ps,
  input  logic [PS_W-1:0]  tck_ps,
  output logic [CNT_W-1:0] trp_cyc
);
  localparam int NW = PS_W + 1;
  localparam logic [NW-1:0] CAP = NW'((64'd1 << CNT_W) - 64'd1);

  logic [NW-1:0] num;
  logic [NW-1:0] rem;
  logic [NW-1:0] quo;
  logic [NW-1:0] div;

  always_comb begin
    div = {1'b0, tck_ps};
    num = {1'b0, trp_ps} + div - NW'(1);
    rem = '0;
    quo = '0;
    for (int i = NW - 1; i >= 0; i--) begin
      rem = {rem[NW-2:0], num[i]};
      if (rem >= div) begin
        rem    = rem - div;
        quo[i] = 1'b1;
      end
    end
    if (quo == '0)      trp_cyc = CNT_W'(1);
    else if (quo > CAP) trp_cyc = CAP[CNT_W-1:0];
    else                trp_cyc = quo[CNT_W-1:0];
  end
endmodule

// File: rtl/bank_rd_tracker.sv
// Follows the latest read burst: open-row read flag, half-burst point, bus window.
module bank_rd_tracker #(
  parameter int CNT_W = 8,
  parameter int CL_W  = 3,
  parameter int BL_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_go,
  input  logic             act_go,
  input  logic             pre_go,
  input  logic [CL_W-1:0]  cfg_cl,
  input  logic [BL_W-1:0]  cfg_bl,
  input  logic [CNT_W-1:0] rd_cnt,
  output logic             in_row,
  output logic             past_half,
  output logic             dq_busy
);
  logic [CNT_W-1:0] half_c;
  logic [CNT_W-1:0] cl_c;
  logic [CNT_W:0]   dq_end;
  logic [CNT_W:0]   cut_at;
  logic             rd_live;

  assign half_c = CNT_W'(cfg_bl >> 1);
  assign cl_c   = CNT_W'(cfg_cl);
  assign cut_at = {1'b0, rd_cnt} + {1'b0, cl_c};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_live <= 1'b0;
      in_row  <= 1'b0;
      dq_end  <= '0;
    end else begin
      if (rd_go) begin
        rd_live <= 1'b1;
        in_row  <= 1'b1;
        dq_end  <= {1'b0, cl_c} + {1'b0, half_c};
      end else begin
        if (act_go) in_row <= 1'b0;
        // output disable follows a precharge by CL cycles
        if (pre_go && rd_live && (cut_at < dq_end)) dq_end <= cut_at;
      end
    end
  end

  assign past_half = rd_cnt >= half_c;
  assign dq_busy   = rd_live && (rd_cnt >= cl_c) && ({1'b0, rd_cnt} < dq_end);

  AST_DQ_QUIET_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && (cfg_cl > CL_W'(1)) |=> !dq_busy); // R11

endmodule

// File: rtl/bank_pre_tracker.sv
module bank_pre_tracker
  import bank_trk_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CL_W  = 3,
  parameter int BL_W  = 5,
  parameter int PS_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_act,
  input  logic             cmd_rd,
  input  logic             cmd_rd_ap,
  input  logic             cmd_pre,
  input  logic [CL_W-1:0]  cfg_cl,
  input  logic [BL_W-1:0]  cfg_bl,
  input  logic [CNT_W-1:0] cfg_tras,
  input  logic [PS_W-1:0]  cfg_trp_ps,
  input  logic [PS_W-1:0]  cfg_tck_ps,
  output logic             act_ok,
  output logic             pre_ok,
  output logic             pre_cut,
  output logic             auto_pre_start,
  output logic             dq_busy,
  output logic             violation
);
  bank_st_t         bank_st;
  logic             ap_pend;
  logic [CNT_W-1:0] trp_cyc;
  logic [TMR_N-1:0] tmr_restart;
  logic [CNT_W-1:0] tmr_cnt [TMR_N];

  logic       multi, any_rd, tras_met, rd_legal;
  logic       act_go, rd_go, pre_go_ext, pre_start, illegal;
  logic       in_row, past_half;

  // ---------------- precharge time in cycles ----------------
  bank_trp_ceil #(.PS_W(PS_W), .CNT_W(CNT_W)) u_trp (
    .trp_ps (cfg_trp_ps),
    .tck_ps (cfg_tck_ps),
    .trp_cyc(trp_cyc)
  );

  // ---------------- elapsed-cycle timers ----------------
  assign tmr_restart[TMR_RAS] = act_go;
  assign tmr_restart[TMR_TRP] = pre_start;
  assign tmr_restart[TMR_RD]  = rd_go;

  for (genvar g = 0; g < TMR_N; g++) begin : g_tmr
    bank_sat_timer #(.W(CNT_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(tmr_restart[g]),
      .cnt    (tmr_cnt[g])
    );
  end

  // ---------------- read burst tracking ----------------
  bank_rd_tracker #(.CNT_W(CNT_W), .CL_W(CL_W), .BL_W(BL_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_go    (rd_go),
    .act_go   (act_go),
    .pre_go   (pre_start),
    .cfg_cl   (cfg_cl),
    .cfg_bl   (cfg_bl),
    .rd_cnt   (tmr_cnt[TMR_RD]),
    .in_row   (in_row),
    .past_half(past_half),
    .dq_busy  (dq_busy)
  );

  // ---------------- permissions ----------------
  assign tras_met = tmr_cnt[TMR_RAS] >= cfg_tras;
  assign pre_ok   = (bank_st == BK_OPEN) && !ap_pend && tras_met;
  assign act_ok   = (bank_st == BK_IDLE) ||
                    ((bank_st == BK_PRECH) && (tmr_cnt[TMR_TRP] >= trp_cyc));
  assign rd_legal = (bank_st == BK_OPEN) && !ap_pend;
  assign pre_cut  = pre_ok && in_row && !past_half;

  // internal precharge: earliest non-truncating point, held back by tRAS
  assign auto_pre_start = (bank_st == BK_OPEN) && ap_pend && past_half && tras_met;

  // ---------------- command acceptance ----------------
  assign multi      = ($countones({cmd_act, cmd_rd, cmd_rd_ap, cmd_pre}) > 1);
  assign any_rd     = cmd_rd | cmd_rd_ap;
  assign act_go     = cmd_act && !multi && act_ok;
  assign rd_go      = any_rd  && !multi && rd_legal;
  assign pre_go_ext = cmd_pre && !multi && pre_ok;
  assign pre_start  = pre_go_ext | auto_pre_start;
  assign illegal    = multi ||
                      (cmd_act && !act_ok) ||
                      (cmd_pre && !pre_ok) ||
                      (any_rd  && !rd_legal);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_st   <= BK_IDLE;
      ap_pend   <= 1'b0;
      violation <= 1'b0;
    end else begin
      violation <= illegal;
      if (act_go) begin
        bank_st <= BK_OPEN;
        ap_pend <= 1'b0;
      end else if (pre_start) begin
        bank_st <= BK_PRECH;
        ap_pend <= 1'b0;
      end else if (rd_go && cmd_rd_ap) begin
        ap_pend <= 1'b1;
      end
    end
  end

  // ---------------- assertions ----------------
  AST_PRE_RESPECTS_TRAS: assert property (@(posedge clk) disable iff (!rst_n)
    pre_start |-> (tmr_cnt[TMR_RAS] >= cfg_tras)); // R2

  AST_AUTO_PRE_AFTER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre_start |-> past_half); // R7

  AST_ACT_WAITS_TRP: assert property (@(posedge clk) disable iff (!rst_n)
    pre_start && (trp_cyc > CNT_W'(1)) |=> !act_ok); // R5

  AST_REJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal && !auto_pre_start |=> $stable(bank_st)); // R9

  AST_AUTO_PRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre_start |=> !auto_pre_start); // R7

endmodule

// File: tb/bank_pre_tracker_bench.sv
`timescale 1ns/1ps
module bank_pre_tracker_bench;

  localparam int SIG_ACT = 0, SIG_PRE = 1, SIG_CUT = 2,
                 SIG_VIOL = 3, SIG_AP = 4, SIG_DQ = 5;
  localparam int WDOG = 5000;

  typedef struct {
    int    cyc;
    int    sig;
    bit    val;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_act = 0, cmd_rd = 0, cmd_rd_ap = 0, cmd_pre = 0;
  logic [2:0]  cfg_cl = 3'd3;
  logic [4:0]  cfg_bl = 5'd8;
  logic [7:0]  cfg_tras = 8'd6;
  logic [15:0] cfg_trp_ps = 16'd15000;
  logic [15:0] cfg_tck_ps = 16'd8000;
  logic act_ok, pre_ok, pre_cut, auto_pre_start, dq_busy, violation;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  bank_pre_tracker u_bank_pre_tracker (
    .clk(clk), .rst_n(rst_n),
    .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_rd_ap(cmd_rd_ap), .cmd_pre(cmd_pre),
    .cfg_cl(cfg_cl), .cfg_bl(cfg_bl), .cfg_tras(cfg_tras),
    .cfg_trp_ps(cfg_trp_ps), .cfg_tck_ps(cfg_tck_ps),
    .act_ok(act_ok), .pre_ok(pre_ok), .pre_cut(pre_cut),
    .auto_pre_start(auto_pre_start), .dq_busy(dq_busy), .violation(violation)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit sample(input int s);
    case (s)
      SIG_ACT: return act_ok;
      SIG_PRE: return pre_ok;
      SIG_CUT: return pre_cut;
      SIG_VIOL: return violation;
      SIG_AP:  return auto_pre_start;
      default: return dq_busy;
    endcase
  endfunction

  function automatic string sname(input int s);
    case (s)
      SIG_ACT: return "act_ok";
      SIG_PRE: return "pre_ok";
      SIG_CUT: return "pre_cut";
      SIG_VIOL: return "violation";
      SIG_AP:  return "auto_pre_start";
      default: return "dq_busy";
    endcase
  endfunction

  task automatic expect_at(input int c, input int s, input bit v, input string req);
    exp_t e;
    e.cyc = c; e.sig = s; e.val = v; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: compare every expectation due in this cycle
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].cyc == cyc) begin
          checks++;
          if (sample(sb[i].sig) !== sb[i].val) begin
            errors++;
            $display("FAIL %s cycle %0d %s: actual %0b expected %0b",
                     sb[i].req, cyc, sname(sb[i].sig), sample(sb[i].sig), sb[i].val);
          end
          sb.delete(i);
        end
      end
    end
  end

  // driver: one command cycle, with its expected violation result
  task automatic drive(input int at, input bit a, input bit r, input bit ra, input bit p,
                       input bit exp_viol, input string req);
    while (cyc < at) @(negedge clk);
    #1;
    if (cyc != at) begin
      checks++; errors++;
      $display("FAIL %s schedule: actual cycle %0d expected %0d", req, cyc, at);
    end
    expect_at(cyc + 1, SIG_VIOL, exp_viol, req);
    cmd_act = a; cmd_rd = r; cmd_rd_ap = ra; cmd_pre = p;
    @(negedge clk); #1;
    cmd_act = 0; cmd_rd = 0; cmd_rd_ap = 0; cmd_pre = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > WDOG) begin
      checks++; errors++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WDOG);
      finish_run();
    end
  end

  initial begin
    int base, a, r, p, a2, r2, a3, b, c, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    base = cyc + 1;
    // R1 reset state
    expect_at(base, SIG_ACT, 1, "R1");
    expect_at(base, SIG_PRE, 0, "R1");
    expect_at(base, SIG_CUT, 0, "R1");
    expect_at(base, SIG_AP,  0, "R1");
    expect_at(base, SIG_DQ,  0, "R1");
    expect_at(base, SIG_VIOL, 0, "R1");

    // ---- truncating precharge during a read ----
    a = base + 1;
    r = a + 3;
    p = r + 3;
    expect_at(a + 1, SIG_ACT, 0, "R2");
    expect_at(a + 5, SIG_PRE, 0, "R2");
    expect_at(a + 3, SIG_PRE, 0, "R3");       // rejected precharge changed nothing
    expect_at(a + 3, SIG_VIOL, 0, "R3");
    expect_at(r + 2, SIG_CUT, 0, "R4");
    expect_at(r + 3, SIG_PRE, 1, "R2");
    expect_at(r + 3, SIG_CUT, 1, "R4");
    expect_at(r + 2, SIG_DQ, 0, "R11");
    expect_at(r + 3, SIG_DQ, 1, "R11");
    expect_at(r + 5, SIG_DQ, 1, "R12");
    expect_at(r + 6, SIG_DQ, 0, "R12");
    expect_at(p + 1, SIG_ACT, 0, "R5");
    expect_at(p + 2, SIG_ACT, 1, "R5");
    drive(a, 1, 0, 0, 0, 0, "R2");
    drive(a + 1, 0, 0, 0, 1, 1, "R3");
    drive(r, 0, 1, 0, 0, 0, "R11");
    drive(p, 0, 0, 0, 1, 0, "R4");

    // ---- autoprecharge held back by tRAS; read while pending ----
    a2 = p + 2;
    r2 = a2 + 1;
    expect_at(r2 + 1, SIG_PRE, 0, "R7");
    expect_at(r2 + 6, SIG_DQ, 1, "R8");
    expect_at(r2 + 7, SIG_DQ, 0, "R8");       // ignored read did not restart the burst
    expect_at(a2 + 5, SIG_AP, 0, "R7");
    expect_at(a2 + 6, SIG_AP, 1, "R7");
    expect_at(a2 + 7, SIG_ACT, 0, "R7");
    expect_at(a2 + 8, SIG_ACT, 1, "R7");
    drive(a2, 1, 0, 0, 0, 0, "R5");
    drive(r2, 0, 0, 1, 0, 0, "R7");
    drive(r2 + 1, 0, 1, 0, 0, 1, "R8");

    // ---- autoprecharge at the half-burst point; illegal commands ----
    a3 = a2 + 8;
    expect_at(a3 + 2, SIG_ACT, 0, "R9");
    expect_at(a3 + 6, SIG_AP, 0, "R7");
    expect_at(a3 + 7, SIG_AP, 1, "R7");
    expect_at(a3 + 8, SIG_AP, 0, "R7");
    expect_at(a3 + 8, SIG_ACT, 0, "R7");
    expect_at(a3 + 9, SIG_ACT, 1, "R7");
    expect_at(a3 + 10, SIG_ACT, 1, "R10");    // ignored activate+precharge pair
    expect_at(a3 + 12, SIG_ACT, 1, "R3");
    expect_at(a3 + 13, SIG_VIOL, 0, "R3");
    drive(a3, 1, 0, 0, 0, 0, "R9");
    drive(a3 + 1, 1, 0, 0, 0, 1, "R9");
    drive(a3 + 3, 0, 0, 1, 0, 0, "R7");
    drive(a3 + 9, 1, 0, 0, 1, 1, "R10");
    drive(a3 + 10, 0, 1, 0, 0, 1, "R8");
    drive(a3 + 11, 0, 0, 0, 1, 1, "R3");

    // ---- full burst, tRP that rounds up to 3 ----
    b = a3 + 14;
    expect_at(b + 5, SIG_PRE, 0, "R2");
    expect_at(b + 6, SIG_PRE, 1, "R2");
    expect_at(b + 6, SIG_CUT, 0, "R4");
    expect_at(b + 7, SIG_DQ, 1, "R11");
    expect_at(b + 8, SIG_DQ, 0, "R11");
    expect_at(b + 8, SIG_ACT, 0, "R6");
    expect_at(b + 9, SIG_ACT, 1, "R6");
    drive(b, 1, 0, 0, 0, 0, "R6");
    cfg_trp_ps = 16'd16001;
    drive(b + 1, 0, 1, 0, 0, 0, "R11");
    drive(b + 6, 0, 0, 0, 1, 0, "R6");

    // ---- tRP of zero gives one cycle ----
    c = b + 9;
    expect_at(c + 7, SIG_ACT, 1, "R6");
    drive(c, 1, 0, 0, 0, 0, "R6");
    cfg_trp_ps = 16'd0;
    drive(c + 6, 0, 0, 0, 1, 0, "R6");

    // ---- exact multiple does not round up ----
    d = c + 7;
    expect_at(d + 7, SIG_ACT, 0, "R6");
    expect_at(d + 8, SIG_ACT, 1, "R6");
    drive(d, 1, 0, 0, 0, 0, "R6");
    cfg_trp_ps = 16'd16000;
    drive(d + 6, 0, 0, 0, 1, 0, "R6");

    repeat (4) @(negedge clk);
    #1;
    foreach (sb[i]) begin
      checks++; errors++;
      $display("FAIL %s cycle %0d %s: actual never sampled expected %0b",
               sb[i].req, sb[i].cyc, sname(sb[i].sig), sb[i].val);
    end
    finish_run();
  end

endmodule